// File: doc/BRIEF.md
# Floating-Point Status and Control Register

This block holds the status and control word of a single-precision floating-point unit. Software loads the word through a write port and reads it back on a read port. Most of the word is fixed: the denormal-flush bit, the rounding mode (round toward zero) and every field for overflow, underflow, inexact and the unimplemented-operation cause always read constant values. Only six bits can change. They are the invalid-operation and division-by-zero bits in each of the cause, enable and sticky-flag fields.

The arithmetic datapath signals the end of each instruction with a completion strobe. With that strobe it gives the instruction's invalid-operation and division-by-zero events and the sign of the expression. The block then does three things:

- It replaces the cause bits with the new events.
- It accumulates the events into the sticky flags.
- In the following cycle, it either pulses a trap request for an enabled event, or tells the datapath which default result to substitute for a masked event.

A separate combinational helper flushes a denormal single-precision operand to a zero that keeps the operand's sign.

Top module: `fpscr_unit`

## Requirements
- R1: After reset the read port shows 0x0004_0001. Each writable bit is 0, DN (bit 18) is 1 and the rounding field (bits 1:0) is 01.
- R2: Bit 18 always reads 1 and bits 1:0 always read 01. Every bit other than 16, 15, 11, 10, 6 and 5 always reads 0. Software writes do not change any of these bits.
- R3: A load (wr_en_i high at a clock edge) copies bits 16 (CV), 15 (CZ), 11 (EV), 10 (EZ), 6 (FV) and 5 (FZ) of wr_data_i into the register. The new value shows on the read port after that edge.
- R4: At a clock edge with done_i high, CV takes the value of inv_i and CZ takes the value of dz_i, whatever their previous values were.
- R5: At a clock edge with done_i high, FV becomes FV | inv_i and FZ becomes FZ | dz_i. Without a load, FV and FZ never go from 1 to 0.
- R6: When a load and a completion strobe come in the same cycle, the event update is applied on top of the written value. The trap and default-result decisions use the enable bits being written.
- R7: trap_o is high for exactly the one cycle after a completion edge in which (inv_i & EV) | (dz_i & EZ) held. Otherwise it is low.
- R8: In the cycle after a completion edge, dflt_sel_o is set as follows, and it is 00 in every other cycle:
  - 01 (quiet NaN) if inv_i was high with EV=0.
  - Otherwise, if inv_i was low and dz_i was high with EZ=0: 10 (+infinity) when inf_sign_i was 0, or 11 (-infinity) when inf_sign_i was 1.
  - Otherwise 00.
- R9: opnd_o equals opnd_i, except when the exponent (bits 30:23) is zero and the mantissa (bits 22:0) is nonzero. In that case opnd_o is opnd_i[31] followed by 31 zero bits.
- R10: In a cycle with neither a load nor a completion strobe, the register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Software load strobe |
| wr_data_i | input | 32 | Software load value |
| rd_data_o | output | 32 | Register read value |
| done_i | input | 1 | Instruction completion strobe |
| inv_i | input | 1 | Invalid-operation event of completing instruction |
| dz_i | input | 1 | Division-by-zero event of completing instruction |
| inf_sign_i | input | 1 | Sign of expression for infinity default |
| trap_o | output | 1 | One-cycle trap request |
| dflt_sel_o | output | 2 | Default result select: 00 none, 01 qNaN, 10 +inf, 11 -inf |
| opnd_i | input | 32 | Single-precision operand to flush |
| opnd_o | output | 32 | Operand with denormals flushed to signed zero |

## Verification
Every writable bit can be seen directly on the read port, so a wrong cause, enable or flag bit shows up one cycle after the edge that set it wrong. A corrupted enable bit may not show right away in the outputs. It shows as a missing or extra trap_o pulse, or a wrong dflt_sel_o code, in the cycle after the next completion strobe that carries that event. A sticky flag that clears without a load is also visible on the read port, and it stays wrong until software writes the register again.

// File: rtl/fpscr_pkg.sv
package fpscr_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned DN_B   = 18;
  localparam int unsigned CV_B   = 16;
  localparam int unsigned CZ_B   = 15;
  localparam int unsigned EV_B   = 11;
  localparam int unsigned EZ_B   = 10;
  localparam int unsigned FV_B   = 6;
  localparam int unsigned FZ_B   = 5;
  localparam logic [1:0]  RM_RTZ = 2'b01;

  typedef enum logic [1:0] {
    DFLT_NONE = 2'b00,
    DFLT_QNAN = 2'b01,
    DFLT_PINF = 2'b10,
    DFLT_NINF = 2'b11
  } dflt_e;

  typedef struct packed {
    logic cv;
    logic cz;
    logic ev;
    logic ez;
    logic fv;
    logic fz;
  } ctl_t;
endpackage

// File: rtl/fpscr_regs.sv
module fpscr_regs
  import fpscr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              done_i,
  input  logic              inv_i,
  input  logic              dz_i,
  output logic              ev_eff_o,
  output logic              ez_eff_o,
  output logic [WORD_W-1:0] rd_data_o
);
  ctl_t q, base, d;

  // value after software load, before the event update
  always_comb begin
    base = q;
    if (wr_en_i) begin
      base.cv = wr_data_i[CV_B];
      base.cz = wr_data_i[CZ_B];
      base.ev = wr_data_i[EV_B];
      base.ez = wr_data_i[EZ_B];
      base.fv = wr_data_i[FV_B];
      base.fz = wr_data_i[FZ_B];
    end
  end

  always_comb begin
    d = base;
    if (done_i) begin
      d.cv = inv_i;
      d.cz = dz_i;
      d.fv = base.fv | inv_i;
      d.fz = base.fz | dz_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d;
  end

  assign ev_eff_o = base.ev;
  assign ez_eff_o = base.ez;

  always_comb begin
    rd_data_o        = '0;
    rd_data_o[DN_B]  = 1'b1;
    rd_data_o[1:0]   = RM_RTZ;
    rd_data_o[CV_B]  = q.cv;
    rd_data_o[CZ_B]  = q.cz;
    rd_data_o[EV_B]  = q.ev;
    rd_data_o[EZ_B]  = q.ez;
    rd_data_o[FV_B]  = q.fv;
    rd_data_o[FZ_B]  = q.fz;
  end
endmodule

// File: rtl/fpscr_gate.sv
module fpscr_gate
  import fpscr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       done_i,
  input  logic       inv_i,
  input  logic       dz_i,
  input  logic       inf_sign_i,
  input  logic       ev_i,
  input  logic       ez_i,
  output logic       trap_o,
  output logic [1:0] dflt_sel_o
);
  logic  trap_d;
  dflt_e sel_d, sel_q;

  assign trap_d = done_i & ((inv_i & ev_i) | (dz_i & ez_i));

  // invalid dominates; a trapped invalid suppresses any default
  always_comb begin
    sel_d = DFLT_NONE;
    if (done_i) begin
      if (inv_i) begin
        if (!ev_i) sel_d = DFLT_QNAN;
      end else if (dz_i && !ez_i) begin
        sel_d = inf_sign_i ? DFLT_NINF : DFLT_PINF;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_o <= 1'b0;
      sel_q  <= DFLT_NONE;
    end else begin
      trap_o <= trap_d;
      sel_q  <= sel_d;
    end
  end

  assign dflt_sel_o = sel_q;
endmodule

// File: rtl/fp_denorm_flush.sv
module fp_denorm_flush #(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23,
  localparam int unsigned FP_W = 1 + EXP_W + MAN_W
) (
  input  logic [FP_W-1:0] val_i,
  output logic [FP_W-1:0] val_o
);
  logic is_denorm;

  assign is_denorm = (val_i[FP_W-2 -: EXP_W] == '0) && (val_i[MAN_W-1:0] != '0);
  assign val_o     = is_denorm ? {val_i[FP_W-1], {(FP_W-1){1'b0}}} : val_i;
endmodule

// File: rtl/fpscr_unit.sv
module fpscr_unit
  import fpscr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic              done_i,
  input  logic              inv_i,
  input  logic              dz_i,
  input  logic              inf_sign_i,
  output logic              trap_o,
  output logic [1:0]        dflt_sel_o,
  input  logic [31:0]       opnd_i,
  output logic [31:0]       opnd_o
);
  logic ev_eff, ez_eff;

  fpscr_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .done_i    (done_i),
    .inv_i     (inv_i),
    .dz_i      (dz_i),
    .ev_eff_o  (ev_eff),
    .ez_eff_o  (ez_eff),
    .rd_data_o (rd_data_o)
  );

  fpscr_gate u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .done_i     (done_i),
    .inv_i      (inv_i),
    .dz_i       (dz_i),
    .inf_sign_i (inf_sign_i),
    .ev_i       (ev_eff),
    .ez_i       (ez_eff),
    .trap_o     (trap_o),
    .dflt_sel_o (dflt_sel_o)
  );

  fp_denorm_flush #(.EXP_W(8), .MAN_W(23)) u_flush (
    .val_i (opnd_i),
    .val_o (opnd_o)
  );
endmodule

// File: rtl/fpscr_unit_chk.sv
module fpscr_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [31:0] wr_data_i,
  input logic [31:0] rd_data_o,
  input logic        done_i,
  input logic        inv_i,
  input logic        dz_i,
  input logic        inf_sign_i,
  input logic        trap_o,
  input logic [1:0]  dflt_sel_o,
  input logic [31:0] opnd_i,
  input logic [31:0] opnd_o
);
  localparam logic [31:0] VAR_MASK = 32'h0001_8C60;

  AST_FIXED_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o & ~VAR_MASK) == 32'h0004_0001); // R2

  AST_CAUSE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (rd_data_o[16] == $past(inv_i)) && (rd_data_o[15] == $past(dz_i))); // R4

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ((rd_data_o[6:5] & $past(rd_data_o[6:5])) == $past(rd_data_o[6:5]))); // R5

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !done_i) |=> $stable(rd_data_o)); // R10

  AST_TRAP_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> ((rd_data_o[16] & rd_data_o[11]) | (rd_data_o[15] & rd_data_o[10]))); // R7

  AST_TRAP_ONLY_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> !trap_o && (dflt_sel_o == 2'b00)); // R8

  AST_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((opnd_i[30:23] == 8'h00) && (opnd_i[22:0] != 23'h0)) |-> (opnd_o == {opnd_i[31], 31'h0})); // R9
endmodule

bind fpscr_unit fpscr_unit_chk u_chk (.*);

// File: tb/tb_fpscr_unit.sv
`timescale 1ns/1ps
module tb_fpscr_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic        done_i = 1'b0, inv_i = 1'b0, dz_i = 1'b0, inf_sign_i = 1'b0;
  logic        trap_o;
  logic [1:0]  dflt_sel_o;
  logic [31:0] opnd_i = '0;
  logic [31:0] opnd_o;

  int n_tests = 0, n_fail = 0;
  bit done_flag = 0;

  // bench model of writable bits
  logic m_cv = 0, m_cz = 0, m_ev = 0, m_ez = 0, m_fv = 0, m_fz = 0;
  logic m_trap = 0;
  logic [1:0] m_sel = 2'b00;

  fpscr_unit dut (.*);

  always #5 clk_i = ~clk_i;

  function automatic logic [31:0] exp_rd();
    logic [31:0] r = 32'h0004_0001;
    r[16] = m_cv; r[15] = m_cz; r[11] = m_ev; r[10] = m_ez; r[6] = m_fv; r[5] = m_fz;
    return r;
  endfunction

  function automatic logic [31:0] exp_flush(logic [31:0] v);
    if (v[30:23] == 8'h00 && v[22:0] != 23'h0) return {v[31], 31'h0};
    return v;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, expv, $time);
    end
  endtask

  // apply one cycle of stimulus, update model, check outputs after the edge
  task automatic step(bit we, logic [31:0] wd, bit dn, bit iv, bit dzv, bit sg, string tag);
    logic ev_e, ez_e;
    wr_en_i = we; wr_data_i = wd; done_i = dn; inv_i = iv; dz_i = dzv; inf_sign_i = sg;
    @(posedge clk_i);
    if (we) begin
      m_cv = wd[16]; m_cz = wd[15]; m_ev = wd[11]; m_ez = wd[10]; m_fv = wd[6]; m_fz = wd[5];
    end
    ev_e = m_ev; ez_e = m_ez;
    m_trap = dn & ((iv & ev_e) | (dzv & ez_e));
    m_sel = 2'b00;
    if (dn) begin
      if (iv) begin
        if (!ev_e) m_sel = 2'b01;
      end else if (dzv && !ez_e) m_sel = sg ? 2'b11 : 2'b10;
      m_cv = iv; m_cz = dzv; m_fv = m_fv | iv; m_fz = m_fz | dzv;
    end
    @(negedge clk_i);
    check({tag, " rd R2 R3 R4 R5 R10"}, rd_data_o, exp_rd());
    check({tag, " trap R7"}, {31'h0, trap_o}, {31'h0, m_trap});
    check({tag, " dflt R8"}, {30'h0, dflt_sel_o}, {30'h0, m_sel});
  endtask

  initial begin
    #1_000_000;
    if (!done_flag) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (2) @(negedge clk_i);
    check("R1 reset", rd_data_o, 32'h0004_0001);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after release", rd_data_o, 32'h0004_0001);
    check("R1 trap", {31'h0, trap_o}, 32'h0);

    // directed corners
    step(1, 32'hFFFF_FFFF, 0, 0, 0, 0, "R2 all ones write");
    step(1, 32'h0000_0000, 0, 0, 0, 0, "R3 clear write");
    step(0, '0, 1, 1, 0, 0, "R8 qnan masked");
    step(0, '0, 1, 0, 1, 1, "R8 -inf masked");
    step(0, '0, 1, 0, 1, 0, "R8 +inf masked");
    step(0, '0, 0, 1, 1, 0, "R10 no strobe");
    step(0, '0, 1, 0, 0, 0, "R4 cause clear R5 flags stay");
    step(1, 32'h0000_0C00, 1, 1, 1, 0, "R6 write+strobe enables");
    step(0, '0, 1, 1, 1, 1, "R7 both trap");
    step(1, 32'h0000_0400, 1, 1, 1, 0, "R6 inv masked dz trap");
    step(1, 32'h0000_0800, 1, 1, 1, 1, "R8 inv trapped suppresses");
    step(1, 32'h0000_0000, 1, 0, 1, 0, "R6 flag over cleared write");

    // flush corners
    opnd_i = 32'h8000_0001; #1 check("R9 neg denorm", opnd_o, exp_flush(opnd_i));
    opnd_i = 32'h007F_FFFF; #1 check("R9 pos denorm", opnd_o, 32'h0000_0000);
    opnd_i = 32'h8000_0000; #1 check("R9 neg zero", opnd_o, 32'h8000_0000);
    opnd_i = 32'h0080_0000; #1 check("R9 min normal", opnd_o, 32'h0080_0000);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] wd, op;
      bit we, dn;
      we = ($urandom % 5) == 0;
      dn = ($urandom % 2) == 0;
      wd = $urandom;
      op = $urandom;
      if (($urandom % 3) == 0) op[30:23] = 8'h00;
      opnd_i = op;
      step(we, wd, dn, 1'($urandom), 1'($urandom), 1'($urandom), "rand");
      check("R9 rand flush", opnd_o, exp_flush(op));
    end

    done_flag = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule